// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block drives the high-side and low-side gate enables of one synchronous buck phase from a PWM command. It never lets both switches conduct together. Each hand-over between the switches waits on feedback instead of a fixed gap. Before the top gate turns on, a comparator must report that the bottom gate voltage is low, and it must keep reporting this for a set number of cycles. Before the bottom gate turns on, a comparator must report that the switching node has fallen. If that report never arrives, the bottom gate is forced on after a bounded wait. This covers a negative inductor current, which keeps the switching node high.

Two minimum widths are applied to the gates. They stop narrow or glitchy PWM pulses from making the gates chatter. The gates also stay off while the phase is disabled or the supply is not good. When the phase is released, the sequencer starts from an idle state with both gates off and then follows the current PWM level.

All timing is given in nanoseconds together with the clock period, and is converted to whole cycles by rounding up. Each cycle count is at least one. The PWM input and both comparator inputs pass through two flip-flops before they are used. The enable and supply-good inputs act on the gates at once.

Top module: `gate_sequencer`

## Requirements
- R1: While `supply_ok` is low, `tg_out` and `bg_out` are both low in the same cycle, whatever `pwm_in` does.
- R2: While `enable` is low, `tg_out` and `bg_out` are both low in the same cycle, whatever `pwm_in` does.
- R3: `tg_out` and `bg_out` are never high in the same cycle.
- R4: When `pwm_in` rises while the bottom gate is on, `bg_out` falls 3 + PROP_C clock edges after the change. This counts two synchronizer edges, one decision edge and PROP_C propagation cycles.
- R5: `tg_out` rises only after the synchronized `bg_low_in` has been high for DEAD_C consecutive cycles. With a comparator that follows the bottom gate within the same cycle, the gap from `bg_out` falling to `tg_out` rising is DEAD_C + 2 cycles.
- R6: When `pwm_in` falls after the minimum on-time has passed, `tg_out` falls 3 + PROP_C edges after the change.
- R7: The bottom gate turns on once the synchronized `ph_low_in` is high. With a comparator that follows the top gate within the same cycle, `bg_out` rises 3 cycles after `tg_out` falls, unless R10 holds it back longer.
- R8: If `ph_low_in` stays low, the turn-off sequence times out and forces `bg_out` on. This happens FORCE_C cycles after the decision edge, which is 3 + FORCE_C edges after `pwm_in` falls.
- R9: Once `tg_out` rises, it stays high for at least MIN_ON_C + PROP_C cycles. A PWM pulse of a single cycle gives a top pulse of exactly that width.
- R10: `bg_out` stays low for at least MIN_OFF_C cycles before each rise. After reset is released with PWM low and the switching node low, the first rise comes exactly MIN_OFF_C cycles later.
- R11: On release from disable or low supply, the sequencer starts idle and then follows the PWM level. With PWM high and bottom-low already asserted, `tg_out` rises DEAD_C + 1 edges after release. With PWM low, the switching node low and the off-time met, `bg_out` rises 2 edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Phase enable; low puts the phase in shutdown |
| supply_ok | input | 1 | Supply-good flag, hysteresis already resolved |
| pwm_in | input | 1 | PWM command, asynchronous |
| bg_low_in | input | 1 | Comparator flag: bottom gate voltage below threshold |
| ph_low_in | input | 1 | Comparator flag: switching node below threshold |
| tg_out | output | 1 | High-side gate enable |
| bg_out | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with its default parameters: a 10 ns clock period and 20/30/40/140/175 ns delays. These give PROP_C=2, DEAD_C=3, MIN_ON_C=4, MIN_OFF_C=14 and FORCE_C=18. With these values the off-time minimum is the binding limit when the bottom gate first turns on after reset. A one-cycle PWM pulse then lands exactly on the boundary where the top minimum width and the off-time minimum give the same answer. The 18-cycle forced turn-on also fits within short runs where negative current is modelled. The random phase varies the comparator lag by up to two cycles, toggles the reverse-current condition, and drops enable or supply in the middle of a sequence.

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int CLK_PS     = 10000,
  parameter int PROP_NS    = 20,
  parameter int DEAD_NS    = 30,
  parameter int MIN_ON_NS  = 40,
  parameter int MIN_OFF_NS = 140,
  parameter int FORCE_NS   = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic supply_ok,
  input  logic pwm_in,
  input  logic bg_low_in,
  input  logic ph_low_in,
  output logic tg_out,
  output logic bg_out
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PROP_C    = to_cyc(PROP_NS);
  localparam int DEAD_C    = to_cyc(DEAD_NS);
  localparam int MIN_ON_C  = to_cyc(MIN_ON_NS);
  localparam int MIN_OFF_C = to_cyc(MIN_OFF_NS);
  localparam int FORCE_C   = to_cyc(FORCE_NS);
  localparam int CMAX      = max2(max2(max2(PROP_C, DEAD_C), max2(MIN_ON_C, MIN_OFF_C)), FORCE_C);
  localparam int CW        = $clog2(CMAX + 1);

  localparam logic [CW-1:0] K_PROP   = CW'(PROP_C - 1);
  localparam logic [CW-1:0] K_DEAD   = CW'(DEAD_C - 1);
  localparam logic [CW-1:0] K_MINON  = CW'(MIN_ON_C - 1);
  localparam logic [CW-1:0] K_MINOFF = CW'(MIN_OFF_C - 1);
  localparam logic [CW-1:0] K_FORCE  = CW'(FORCE_C - 1);
  localparam logic [CW-1:0] K_SAT    = CW'(CMAX);
  localparam logic [CW-1:0] K_OFFSAT = CW'(MIN_OFF_C);
  localparam logic [CW-1:0] K_ONSAT  = CW'(MIN_ON_C);

  typedef enum logic [2:0] {
    S_IDLE, S_BG_ON, S_BG_DROP, S_DEAD, S_TG_ON, S_TG_DROP, S_BG_WAIT
  } seq_t;

  seq_t          state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] offc;
  logic [1:0]    pwm_q, bgl_q, phl_q;

  wire active = enable & supply_ok;
  wire pwm_s  = pwm_q[1];
  wire bgl_s  = bgl_q[1];
  wire phl_s  = phl_q[1];
  wire bg_st  = (state == S_BG_ON) || (state == S_BG_DROP);
  wire tg_st  = (state == S_TG_ON) || (state == S_TG_DROP);
  wire off_ok = offc >= K_MINOFF;

  assign tg_out = active & tg_st;
  assign bg_out = active & bg_st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwm_q <= '0;
      bgl_q <= '0;
      phl_q <= '0;
    end else begin
      pwm_q <= {pwm_q[0], pwm_in};
      bgl_q <= {bgl_q[0], bg_low_in};
      phl_q <= {phl_q[0], ph_low_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            offc <= '0;
    else if (bg_st)        offc <= '0;
    else if (offc != K_OFFSAT) offc <= offc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (!active) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt   <= '0;
          state <= pwm_s ? S_DEAD : S_BG_WAIT;
        end
        S_BG_ON: begin
          cnt <= '0;
          if (pwm_s) state <= S_BG_DROP;
        end
        S_BG_DROP:
          if (cnt == K_PROP) begin
            state <= S_DEAD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_DEAD:
          if (!bgl_s) cnt <= '0;
          else if (cnt == K_DEAD) begin
            state <= S_TG_ON;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_TG_ON:
          if (!pwm_s && cnt >= K_MINON) begin
            state <= S_TG_DROP;
            cnt   <= '0;
          end else if (cnt != K_SAT) cnt <= cnt + 1'b1;
        S_TG_DROP: begin
          cnt <= cnt + 1'b1;
          if (cnt == K_PROP) state <= S_BG_WAIT;
        end
        S_BG_WAIT:
          if (pwm_s) begin
            state <= S_DEAD;
            cnt   <= '0;
          end else if ((phl_s || cnt >= K_FORCE) && off_ok) begin
            state <= S_BG_ON;
            cnt   <= '0;
          end else if (cnt != K_SAT) cnt <= cnt + 1'b1;
        default: begin
          state <= S_IDLE;
          cnt   <= '0;
        end
      endcase
    end

  logic [CW-1:0] ton_run, boff_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ton_run  <= '0;
      boff_run <= '0;
    end else begin
      ton_run  <= !tg_out ? '0 : (ton_run == K_ONSAT) ? ton_run : ton_run + 1'b1;
      boff_run <= bg_out ? '0 : (boff_run == K_OFFSAT) ? boff_run : boff_run + 1'b1;
    end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tg_out && bg_out));

  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state == S_IDLE));

  p_tg_after_bglow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg_out) |-> $past(bgl_s));

  p_min_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tg_out) && active) |-> (ton_run >= K_ONSAT));

  p_min_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_out) |-> (boff_run >= K_OFFSAT));

endmodule

// File: tb/test_gate_sequencer.sv
module test_gate_sequencer;

  localparam int CLK_PS = 10000;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PROP_C    = cyc(20);
  localparam int DEAD_C    = cyc(30);
  localparam int MIN_ON_C  = cyc(40);
  localparam int MIN_OFF_C = cyc(140);
  localparam int FORCE_C   = cyc(175);

  function automatic int lat_edge();   return 3 + PROP_C;            endfunction
  function automatic int dead_gap();   return DEAD_C + 2;            endfunction
  function automatic int narrow_on();  return MIN_ON_C + PROP_C;     endfunction
  function automatic int narrow_off();
    int t;
    t = dead_gap() + narrow_on() + 3;
    return (t > MIN_OFF_C) ? t : MIN_OFF_C;
  endfunction

  logic clk = 1'b0;
  logic rst_n, enable, supply_ok, pwm_in, bg_low_in, ph_low_in;
  wire  tg_out, bg_out;

  always #5 clk = ~clk;

  gate_sequencer i_gate_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_ok(supply_ok),
    .pwm_in(pwm_in), .bg_low_in(bg_low_in), .ph_low_in(ph_low_in),
    .tg_out(tg_out), .bg_out(bg_out)
  );

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  bit  rev = 1'b0;
  int  dbg = 0, dph = 0;
  logic [3:0] bgh = '0, tgh = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    bg_low_in = 1'b1;
    ph_low_in = 1'b1;
  end

  always @(negedge clk) begin
    #2;
    bgh = {bgh[2:0], bg_out};
    tgh = {tgh[2:0], tg_out};
    bg_low_in = !bgh[dbg];
    ph_low_in = !tgh[dph] && !rev;
  end

  int   m_ton = 0, m_boff = 0;
  logic tg_p = 1'b0, bg_p = 1'b0;

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      m_ton = 0; m_boff = 0; tg_p = 1'b0; bg_p = 1'b0;
    end else if (!done) begin
      check(!(tg_out && bg_out), "R3 overlap", {tg_out, bg_out}, 0);
      if (!supply_ok) check(!tg_out && !bg_out, "R1 gates with supply low", {tg_out, bg_out}, 0);
      if (!enable)    check(!tg_out && !bg_out, "R2 gates with enable low", {tg_out, bg_out}, 0);
      if (tg_out && !tg_p) check(m_boff >= dead_gap(), "R5 dead time before top", m_boff, dead_gap());
      if (!tg_out && tg_p && enable && supply_ok)
        check(m_ton >= MIN_ON_C + PROP_C, "R9 top width", m_ton, MIN_ON_C + PROP_C);
      if (bg_out && !bg_p) check(m_boff >= MIN_OFF_C, "R10 bottom off time", m_boff, MIN_OFF_C);
      m_ton  = tg_out ? m_ton + 1 : 0;
      m_boff = bg_out ? 0 : m_boff + 1;
      tg_p = tg_out;
      bg_p = bg_out;
    end
  end

  task automatic measure(input bit top, input bit val, output int n);
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (((top ? tg_out : bg_out) != val) && n < 400);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      report();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EC0_1218));
    rst_n = 1'b0; enable = 1'b1; supply_ok = 1'b1; pwm_in = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(!tg_out && !bg_out, "R1 reset state", {tg_out, bg_out}, 0);

    @(negedge clk) rst_n = 1'b1;
    measure(0, 1, n);
    check(n == MIN_OFF_C, "R10 first bottom turn-on after reset", n, MIN_OFF_C);
    repeat (10) @(negedge clk);

    @(negedge clk) pwm_in = 1'b1;
    measure(0, 0, n);
    check(n == lat_edge(), "R4 bottom off after PWM rise", n, lat_edge());
    measure(1, 1, n);
    check(n == dead_gap(), "R5 adaptive dead time", n, dead_gap());
    repeat (20) @(negedge clk);
    @(negedge clk) pwm_in = 1'b0;
    measure(1, 0, n);
    check(n == lat_edge(), "R6 top off after PWM fall", n, lat_edge());
    measure(0, 1, n);
    check(n == 3, "R7 bottom on after phase low", n, 3);
    repeat (20) @(negedge clk);

    @(negedge clk) pwm_in = 1'b1;
    @(negedge clk) pwm_in = 1'b0;
    measure(0, 0, n);
    check(n == lat_edge() - 1, "R4 narrow pulse bottom off", n, lat_edge() - 1);
    measure(1, 1, n);
    check(n == dead_gap(), "R5 narrow pulse dead time", n, dead_gap());
    measure(1, 0, n);
    check(n == narrow_on(), "R9 narrow pulse top width", n, narrow_on());
    measure(0, 1, n);
    check(n + dead_gap() + narrow_on() == narrow_off(), "R10 narrow pulse off time",
          n + dead_gap() + narrow_on(), narrow_off());
    repeat (20) @(negedge clk);

    rev = 1'b1;
    @(negedge clk) pwm_in = 1'b1;
    repeat (25) @(negedge clk);
    @(negedge clk) pwm_in = 1'b0;
    measure(0, 1, n);
    check(n == 3 + FORCE_C, "R8 forced bottom turn-on", n, 3 + FORCE_C);
    rev = 1'b0;
    repeat (20) @(negedge clk);

    @(negedge clk) pwm_in = 1'b1;
    repeat (25) @(negedge clk);
    @(negedge clk) enable = 1'b0;
    #1 check(!tg_out && !bg_out, "R2 disable cuts gates", {tg_out, bg_out}, 0);
    repeat (5) @(negedge clk);
    @(negedge clk) enable = 1'b1;
    measure(1, 1, n);
    check(n == DEAD_C + 1, "R11 restart into top", n, DEAD_C + 1);
    repeat (10) @(negedge clk);

    @(negedge clk) supply_ok = 1'b0;
    #1 check(!tg_out && !bg_out, "R1 supply loss cuts gates", {tg_out, bg_out}, 0);
    @(negedge clk) pwm_in = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk) pwm_in = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk) pwm_in = 1'b0;
    repeat (20) @(negedge clk);
    #1 check(!tg_out && !bg_out, "R1 PWM ignored with supply low", {tg_out, bg_out}, 0);
    @(negedge clk) supply_ok = 1'b1;
    measure(0, 1, n);
    check(n == 2, "R11 restart into bottom", n, 2);
    repeat (20) @(negedge clk);

    for (int s = 0; s < 1500; s++) begin
      int hi, lo;
      hi = $urandom_range(1, 30);
      lo = $urandom_range(1, 40);
      if ($urandom_range(0, 9) == 0) rev = !rev;
      dbg = $urandom_range(0, 1);
      dph = $urandom_range(0, 2);
      if ($urandom_range(0, 29) == 0) begin
        @(negedge clk);
        if ($urandom_range(0, 1) == 1) enable = 1'b0; else supply_ok = 1'b0;
        repeat ($urandom_range(1, 5)) @(negedge clk);
        enable = 1'b1; supply_ok = 1'b1;
      end
      @(negedge clk) pwm_in = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk) pwm_in = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end

    repeat (40) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

endmodule